// File: doc/BRIEF.md
# Auto Crossover Link Bring-Up Sequencer

This block brings up a twisted-pair port whose cable wiring is not known in advance. After reset it drives a crossover-select output, starting in straight (MDI) mode. It then polls the PHY status register through a simple read-request port: a register number goes out, and 16 bits of data come back with a one-cycle done strobe. After each poll that shows no link, it flips the crossover select and tries again. The number of attempts is bounded.

Once a poll reports link, the block reads the status register again. If auto-negotiation has completed, it reads a vendor status register to find speed and duplex. When the local PHY can auto-negotiate, it then walks a chain of conditional reads to decide whether pause frames may be used. The outcome is held on link, speed, duplex and pause flags, together with a final done or fail indication. These stay until the next reset. MDIO serial framing and the PHY itself sit outside this block.

Top module: `mdix_link_resolver`

## Requirements
- R1: After reset, xover_sel is 0 (straight mode) and link_up, speed_100, full_duplex, pause_ok, done and fail are all 0. The first link poll is issued in straight mode.
- R2: Before every link poll the block waits at least RETRY_CYCLES clock cycles, and mdio_req stays low during that wait.
- R3: A link poll reads register 1; bit 2 set means link. The attempt with index k (counting from 0) is made with xover_sel equal to k mod 2. The select flips after every failed poll that is followed by another attempt.
- R4: If MAX_TRIES polls all fail, fail goes to 1, done, link_up and the other flags stay 0, and no further reads are issued.
- R5: After link is seen, register 1 is read once more. If its bit 5 (negotiation complete) is 0, the block finishes with link_up=1, speed_100=0, full_duplex=0, pause_ok=0, and register 31 is not read.
- R6: If that bit 5 is 1, register 31 is read and its bits 4:2 give the mode: code 1 = 10 half, 5 = 10 full, 2 = 100 half, 6 = 100 full (speed_100=1 for codes 2 and 6, full_duplex=1 for codes 5 and 6). Any other code leaves both flags 0.
- R7: Pause chain. Only if bit 3 of the second register-1 read is set is register 6 read. Only if register 6 bit 0 is set is register 4 read. Only if register 4 bit 10 is set is register 5 read. pause_ok equals register 5 bit 10 and is 0 whenever the chain stops early.
- R8: Every read goes to PHY address PHY_ADDR. mdio_req and mdio_reg stay stable until mdio_done is seen, and only one read is outstanding at a time.
- R9: done and fail are never both 1, each holds until reset once set, and link_up equals done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mdio_req | output | 1 | Read request, held until mdio_done |
| mdio_phy | output | 5 | PHY address of the read |
| mdio_reg | output | 5 | Register number of the read |
| mdio_done | input | 1 | One-cycle strobe: read data valid |
| mdio_data | input | 16 | Read data, sampled with mdio_done |
| xover_sel | output | 1 | 0 = straight (MDI), 1 = crossover (MDIX) |
| link_up | output | 1 | Link established |
| speed_100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s or unresolved |
| full_duplex | output | 1 | 1 = full duplex |
| pause_ok | output | 1 | Both ends advertise pause |
| done | output | 1 | Bring-up finished with link |
| fail | output | 1 | Attempt budget exhausted without link |

## Verification
Cables that need straight or crossover wiring, and links that only appear after several attempts, show whether the select alternates correctly and whether the attempt count is right. This includes a link found on the very last allowed attempt and a link that never comes, which separates an off-by-one budget from a correct one. Directed cases break the post-link chain at each point in turn: negotiation incomplete, no local ability, partner not able, no local pause advertised. They show that each register read is truly conditional. Every listed speed code and an unlisted one check the decode. Random cases mix all of these, with random filler in the unused data bits and a random handshake latency.

// File: rtl/mdix_pkg.sv
package mdix_pkg;

  // PHY register numbers used by the sequence
  localparam logic [4:0] REG_STATUS  = 5'd1;
  localparam logic [4:0] REG_ADVERT  = 5'd4;
  localparam logic [4:0] REG_PARTNER = 5'd5;
  localparam logic [4:0] REG_ANEXP   = 5'd6;
  localparam logic [4:0] REG_VSTAT   = 5'd31;

  typedef enum logic [3:0] {
    ST_DELAY, ST_POLL, ST_CONFIRM, ST_SPEED,
    ST_ANEXP, ST_ADVERT, ST_PARTNER, ST_DONE, ST_FAIL
  } seq_state_t;

  // Only the data bits the sequence ever looks at are kept after a read.
  typedef struct packed {
    logic       b10;   // pause (regs 4 and 5)
    logic       b5;    // negotiation complete (reg 1)
    logic [2:0] b4_2;  // reg 31 mode code; in reg 1: [0]=link, [1]=aneg able
    logic       b0;    // partner can negotiate (reg 6)
  } rd_bits_t;

  typedef struct packed {
    logic fast;
    logic full;
  } port_mode_t;

  function automatic port_mode_t decode_mode(input logic [2:0] code);
    port_mode_t m;
    case (code)
      3'd1:    m = '{fast: 1'b0, full: 1'b0};
      3'd5:    m = '{fast: 1'b0, full: 1'b1};
      3'd2:    m = '{fast: 1'b1, full: 1'b0};
      3'd6:    m = '{fast: 1'b1, full: 1'b1};
      default: m = '{fast: 1'b0, full: 1'b0};
    endcase
    return m;
  endfunction

  function automatic logic is_read_state(input seq_state_t s);
    return (s == ST_POLL) || (s == ST_CONFIRM) || (s == ST_SPEED) ||
           (s == ST_ANEXP) || (s == ST_ADVERT) || (s == ST_PARTNER);
  endfunction

  function automatic logic [4:0] reg_of_state(input seq_state_t s);
    case (s)
      ST_SPEED:   return REG_VSTAT;
      ST_ANEXP:   return REG_ANEXP;
      ST_ADVERT:  return REG_ADVERT;
      ST_PARTNER: return REG_PARTNER;
      default:    return REG_STATUS;
    endcase
  endfunction

endpackage

// File: rtl/mdix_retry_timer.sv
module mdix_retry_timer #(
  parameter int CYCLES = 200_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic running,
  output logic expire
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt   <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt   <= LOAD;
    end else if (run_q) begin
      if (cnt == '0) run_q <= 1'b0;
      else           cnt   <= cnt - 1'b1;
    end
  end

  assign running = run_q;
  assign expire  = run_q && (cnt == '0);

  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt <= LOAD));
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run_q);
endmodule

// File: rtl/mdix_mdio_reader.sv
module mdix_mdio_reader
  import mdix_pkg::*;
#(
  parameter int PHY_ADDR = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [4:0]  addr,
  output logic        mdio_req,
  output logic [4:0]  mdio_phy,
  output logic [4:0]  mdio_reg,
  input  logic        mdio_done,
  input  logic [15:0] mdio_data,
  output logic        rd_valid,
  output rd_bits_t    rd_bits
);
  logic       req_q;
  logic [4:0] reg_q;
  logic       valid_q;
  rd_bits_t   bits_q;
  rd_bits_t   bits_in;
  logic       accept;
  logic       unused_bits;

  assign bits_in     = '{b10: mdio_data[10], b5: mdio_data[5],
                         b4_2: mdio_data[4:2], b0: mdio_data[0]};
  assign unused_bits = ^{mdio_data[15:11], mdio_data[9:6], mdio_data[1]};
  assign accept      = req_q && mdio_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      reg_q   <= '0;
      valid_q <= 1'b0;
      bits_q  <= '0;
    end else begin
      valid_q <= accept;
      if (accept) begin
        req_q  <= 1'b0;
        bits_q <= bits_in;
      end else if (start) begin
        req_q <= 1'b1;
        reg_q <= addr;
      end
    end
  end

  assign mdio_req = req_q;
  assign mdio_reg = reg_q;
  assign mdio_phy = 5'(PHY_ADDR);
  assign rd_valid = valid_q;
  assign rd_bits  = bits_q;

  a_r8_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !mdio_done) |=> (req_q && $stable(reg_q)));
  a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !req_q);
  a_r8_valid_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(mdio_done));
endmodule

// File: rtl/mdix_seq_fsm.sv
module mdix_seq_fsm
  import mdix_pkg::*;
#(
  parameter int MAX_TRIES = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tmr_expire,
  input  logic       rd_valid,
  input  rd_bits_t   rd_bits,
  output logic       tmr_start,
  output logic       rd_start,
  output logic [4:0] rd_addr,
  output logic       xover,
  output logic       done,
  output logic       fail,
  output logic       cap_mode,
  output logic       cap_pause,
  output logic       set_link
);
  localparam int TRY_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
  localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRIES - 1);

  seq_state_t       state, nxt_state;
  logic             armed, nxt_armed;
  logic [TRY_W-1:0] tries, nxt_tries;
  logic             xover_q, nxt_xover;
  logic             an_able, nxt_able;
  logic             poll_miss;
  logic             step_end;

  assign step_end  = armed && rd_valid && is_read_state(state);
  assign poll_miss = step_end && (state == ST_POLL) && !rd_bits.b4_2[0];

  always_comb begin
    nxt_state = state;
    nxt_armed = armed;
    nxt_tries = tries;
    nxt_xover = xover_q;
    nxt_able  = an_able;
    tmr_start = 1'b0;
    rd_start  = 1'b0;
    cap_mode  = 1'b0;
    cap_pause = 1'b0;
    if (state == ST_DELAY) begin
      if (!armed) begin
        tmr_start = 1'b1;
        nxt_armed = 1'b1;
      end else if (tmr_expire) begin
        nxt_armed = 1'b0;
        nxt_state = ST_POLL;
      end
    end else if (is_read_state(state)) begin
      if (!armed) begin
        rd_start  = 1'b1;
        nxt_armed = 1'b1;
      end else if (rd_valid) begin
        nxt_armed = 1'b0;
        case (state)
          ST_POLL: begin
            if (rd_bits.b4_2[0])       nxt_state = ST_CONFIRM;
            else if (tries == LAST_TRY) nxt_state = ST_FAIL;
            else begin
              nxt_tries = tries + 1'b1;
              nxt_xover = !xover_q;
              nxt_state = ST_DELAY;
            end
          end
          ST_CONFIRM: begin
            nxt_able  = rd_bits.b4_2[1];
            nxt_state = rd_bits.b5 ? ST_SPEED : ST_DONE;
          end
          ST_SPEED: begin
            cap_mode  = 1'b1;
            nxt_state = an_able ? ST_ANEXP : ST_DONE;
          end
          ST_ANEXP:  nxt_state = rd_bits.b0  ? ST_ADVERT  : ST_DONE;
          ST_ADVERT: nxt_state = rd_bits.b10 ? ST_PARTNER : ST_DONE;
          ST_PARTNER: begin
            cap_pause = 1'b1;
            nxt_state = ST_DONE;
          end
          default: nxt_state = state;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_DELAY;
      armed   <= 1'b0;
      tries   <= '0;
      xover_q <= 1'b0;
      an_able <= 1'b0;
    end else begin
      state   <= nxt_state;
      armed   <= nxt_armed;
      tries   <= nxt_tries;
      xover_q <= nxt_xover;
      an_able <= nxt_able;
    end
  end

  assign rd_addr  = reg_of_state(state);
  assign xover    = xover_q;
  assign done     = (state == ST_DONE);
  assign fail     = (state == ST_FAIL);
  assign set_link = (nxt_state == ST_DONE) && (state != ST_DONE);

  a_r3_flip_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_miss && tries != LAST_TRY) |=> (xover_q != $past(xover_q)));
  a_r3_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_miss |=> $stable(xover_q));
  a_r4_fail_at_budget: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_miss && tries == LAST_TRY) |=> fail);
  a_r4_tries_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= LAST_TRY);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail);
endmodule

// File: rtl/mdix_result_regs.sv
module mdix_result_regs
  import mdix_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_mode,
  input  logic [2:0] mode_code,
  input  logic       cap_pause,
  input  logic       pause_bit,
  input  logic       set_link,
  output logic       link_up,
  output logic       speed_100,
  output logic       full_duplex,
  output logic       pause_ok
);
  port_mode_t mode_dec;
  assign mode_dec = decode_mode(mode_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_up     <= 1'b0;
      speed_100   <= 1'b0;
      full_duplex <= 1'b0;
      pause_ok    <= 1'b0;
    end else begin
      if (set_link) link_up <= 1'b1;
      if (cap_mode) begin
        speed_100   <= mode_dec.fast;
        full_duplex <= mode_dec.full;
      end
      if (cap_pause) pause_ok <= pause_bit;
    end
  end

  a_r9_link_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |=> link_up);
  a_r7_pause_once: assert property (@(posedge clk) disable iff (!rst_n)
    pause_ok && !$past(pause_ok) |-> $past(cap_pause));
endmodule

// File: rtl/mdix_link_resolver.sv
module mdix_link_resolver
  import mdix_pkg::*;
#(
  parameter int PHY_ADDR     = 6,
  parameter int RETRY_CYCLES = 200_000_000,
  parameter int MAX_TRIES    = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mdio_req,
  output logic [4:0]  mdio_phy,
  output logic [4:0]  mdio_reg,
  input  logic        mdio_done,
  input  logic [15:0] mdio_data,
  output logic        xover_sel,
  output logic        link_up,
  output logic        speed_100,
  output logic        full_duplex,
  output logic        pause_ok,
  output logic        done,
  output logic        fail
);
  // Named internal events, shared by the sub-blocks and the assertions
  logic       tmr_start, tmr_running, tmr_expire;
  logic       rd_start, rd_valid;
  logic [4:0] rd_addr;
  rd_bits_t   rd_bits;
  logic       cap_mode, cap_pause, set_link;

  mdix_retry_timer #(.CYCLES(RETRY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start),
    .running(tmr_running), .expire(tmr_expire)
  );

  mdix_mdio_reader #(.PHY_ADDR(PHY_ADDR)) u_reader (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .addr(rd_addr),
    .mdio_req(mdio_req), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_done(mdio_done), .mdio_data(mdio_data),
    .rd_valid(rd_valid), .rd_bits(rd_bits)
  );

  mdix_seq_fsm #(.MAX_TRIES(MAX_TRIES)) u_seq (
    .clk(clk), .rst_n(rst_n), .tmr_expire(tmr_expire),
    .rd_valid(rd_valid), .rd_bits(rd_bits),
    .tmr_start(tmr_start), .rd_start(rd_start), .rd_addr(rd_addr),
    .xover(xover_sel), .done(done), .fail(fail),
    .cap_mode(cap_mode), .cap_pause(cap_pause), .set_link(set_link)
  );

  mdix_result_regs u_result (
    .clk(clk), .rst_n(rst_n),
    .cap_mode(cap_mode), .mode_code(rd_bits.b4_2),
    .cap_pause(cap_pause), .pause_bit(rd_bits.b10),
    .set_link(set_link),
    .link_up(link_up), .speed_100(speed_100),
    .full_duplex(full_duplex), .pause_ok(pause_ok)
  );

  a_r2_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_running |-> !mdio_req);
  a_r9_link_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    link_up == done);
  a_r4_fail_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !(link_up || speed_100 || full_duplex || pause_ok || mdio_req));
  a_r3_select_steady_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req |=> $stable(xover_sel));
endmodule

// File: tb/mdix_link_resolver_test.sv
`timescale 1ns/1ps
module mdix_link_resolver_test;
  localparam int PHY  = 6;
  localparam int DLY  = 10;
  localparam int TRYS = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdio_req;
  logic [4:0]  mdio_phy, mdio_reg;
  logic        mdio_done = 1'b0;
  logic [15:0] mdio_data = '0;
  logic        xover_sel, link_up, speed_100, full_duplex, pause_ok, done, fail;

  always #2.5 clk = ~clk;

  mdix_link_resolver #(.PHY_ADDR(PHY), .RETRY_CYCLES(DLY), .MAX_TRIES(TRYS)) uut (
    .clk(clk), .rst_n(rst_n), .mdio_req(mdio_req), .mdio_phy(mdio_phy),
    .mdio_reg(mdio_reg), .mdio_done(mdio_done), .mdio_data(mdio_data),
    .xover_sel(xover_sel), .link_up(link_up), .speed_100(speed_100),
    .full_duplex(full_duplex), .pause_ok(pause_ok), .done(done), .fail(fail)
  );

  int total = 0;
  int bad   = 0;

  // scenario of the modelled PHY and cable
  int         sc_mode, sc_min;
  logic       sc_anc, sc_abl, sc_par, sc_adv, sc_lpp;
  logic [2:0] sc_code;

  // observations
  int   n_rd [32];
  int   polls, bad_phy, bad_sel, bad_gap;
  logic linked;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] phy_word(input logic [4:0] r, input logic lk);
    logic [15:0] w;
    w = 16'($urandom);
    case (r)
      5'd1:  begin w[2] = lk; w[3] = sc_abl; w[5] = sc_anc; end
      5'd31: w[4:2] = sc_code;
      5'd6:  w[0]  = sc_par;
      5'd4:  w[10] = sc_adv;
      5'd5:  w[10] = sc_lpp;
      default: ;
    endcase
    return w;
  endfunction

  // PHY and handshake model, all at the falling edge
  initial begin
    logic       prev_req, busy, lk;
    int         lat, idle;
    logic [4:0] cur_reg;
    prev_req = 1'b0; busy = 1'b0; lat = 0; idle = 0; cur_reg = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_req = 1'b0; busy = 1'b0; idle = 0; mdio_done = 1'b0;
        continue;
      end
      mdio_done = 1'b0;
      if (mdio_req && !prev_req) begin
        cur_reg = mdio_reg;
        n_rd[mdio_reg]++;
        if (mdio_phy != 5'(PHY)) bad_phy++;
        if (mdio_reg == 5'd1 && !linked) begin
          if (xover_sel != 1'(polls % 2)) bad_sel++;
          if (idle < DLY) bad_gap++;
        end
        lat  = int'($urandom % 4);
        busy = 1'b1;
      end
      if (busy) begin
        if (lat == 0) begin
          lk = 1'b1;
          if (cur_reg == 5'd1 && !linked) begin
            lk = (int'(xover_sel) == sc_mode) && (polls >= sc_min);
            if (lk) linked = 1'b1;
            polls++;
          end
          mdio_data = phy_word(cur_reg, lk);
          mdio_done = 1'b1;
          busy      = 1'b0;
        end else lat--;
      end
      idle     = mdio_req ? 0 : idle + 1;
      prev_req = mdio_req;
    end
  end

  task automatic run_case(input string name);
    int  k_hit, exp_polls, waited;
    bit  ok_link, r31, r6, r4, r5;
    bit  e_fast, e_full, e_pause;
    rst_n = 1'b0;
    for (int i = 0; i < 32; i++) n_rd[i] = 0;
    polls = 0; bad_phy = 0; bad_sel = 0; bad_gap = 0; linked = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(xover_sel == 1'b0 && !done && !fail && !link_up && !speed_100 &&
          !full_duplex && !pause_ok, "R1", {name, " reset outputs"},
          {xover_sel, done, fail, link_up, speed_100, full_duplex, pause_ok}, 0);

    // expected outcome, computed from the requirements
    k_hit = -1;
    for (int k = 0; k < TRYS; k++)
      if (k_hit < 0 && (k % 2) == sc_mode && k >= sc_min) k_hit = k;
    ok_link   = (k_hit >= 0);
    exp_polls = ok_link ? k_hit + 1 : TRYS;
    r31 = ok_link && sc_anc;
    r6  = r31 && sc_abl;
    r4  = r6 && sc_par;
    r5  = r4 && sc_adv;
    e_fast  = r31 && (sc_code == 3'd2 || sc_code == 3'd6);
    e_full  = r31 && (sc_code == 3'd5 || sc_code == 3'd6);
    e_pause = r5 && sc_lpp;

    waited = 0;
    while (!(done || fail) && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    repeat (3 * DLY) @(negedge clk);

    check(done == ok_link, "R9", {name, " done"}, done, ok_link);
    check(fail == !ok_link, "R4", {name, " fail"}, fail, !ok_link);
    check(link_up == ok_link, "R9", {name, " link_up"}, link_up, ok_link);
    check(polls == exp_polls, "R3", {name, " link polls"}, polls, exp_polls);
    check(n_rd[1] == exp_polls + int'(ok_link), "R5", {name, " status reads"},
          n_rd[1], exp_polls + int'(ok_link));
    check(bad_sel == 0, "R3", {name, " select per attempt"}, bad_sel, 0);
    check(bad_gap == 0, "R2", {name, " wait before poll"}, bad_gap, 0);
    check(bad_phy == 0, "R8", {name, " phy address"}, bad_phy, 0);
    check(n_rd[31] == int'(r31), "R6", {name, " reg31 reads"}, n_rd[31], int'(r31));
    check(speed_100 == e_fast, "R6", {name, " speed_100"}, speed_100, e_fast);
    check(full_duplex == e_full, "R6", {name, " full_duplex"}, full_duplex, e_full);
    check(n_rd[6] == int'(r6) && n_rd[4] == int'(r4) && n_rd[5] == int'(r5), "R7",
          {name, " pause chain reads"}, n_rd[6] * 100 + n_rd[4] * 10 + n_rd[5],
          int'(r6) * 100 + int'(r4) * 10 + int'(r5));
    check(pause_ok == e_pause, "R7", {name, " pause_ok"}, pause_ok, e_pause);
  endtask

  task automatic set_sc(input int m, input int mn, input logic anc, input logic abl,
                        input logic par, input logic adv, input logic lpp,
                        input logic [2:0] code);
    sc_mode = m; sc_min = mn; sc_anc = anc; sc_abl = abl;
    sc_par = par; sc_adv = adv; sc_lpp = lpp; sc_code = code;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    set_sc(0, 0, 1, 1, 1, 1, 1, 3'd6); run_case("R1_R6_R7 straight 100 full pause");
    set_sc(1, 0, 1, 1, 1, 1, 0, 3'd5); run_case("R3 crossover 10 full");
    set_sc(0, 3, 1, 0, 1, 1, 1, 3'd2); run_case("R3 late link 100 half");
    set_sc(0, 9, 1, 1, 1, 1, 1, 3'd6); run_case("R4 never links");
    set_sc(1, 5, 1, 1, 1, 1, 1, 3'd1); run_case("R4 link on last attempt");
    set_sc(0, 0, 0, 1, 1, 1, 1, 3'd6); run_case("R5 negotiation incomplete");
    set_sc(1, 1, 1, 0, 1, 1, 1, 3'd1); run_case("R7 no local ability");
    set_sc(0, 0, 1, 1, 0, 1, 1, 3'd6); run_case("R7 partner not able");
    set_sc(0, 0, 1, 1, 1, 0, 1, 3'd6); run_case("R7 no local pause");
    set_sc(0, 0, 1, 1, 1, 1, 1, 3'd3); run_case("R6 unlisted code");
    for (int n = 0; n < 14; n++) begin
      set_sc(int'($urandom % 2), int'($urandom % 8), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
      run_case($sformatf("R8 random %0d", n));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule